// File: doc/BRIEF.md
# TDMA Frame Generator

This block turns up to four byte-wide message sources into a serial bit stream of framed TDMA traffic for a one-way paging link. Every frame opens with a synchronization guard, carries a 24-bit header and four 8-bit control words, and then carries each message that is ready. A spacer comes before each message. Only the sections that carry data are sent, so a frame is as long as its content and no longer.

Bits advance only on a bit-rate tick, so one fast clock can pace any link rate. Frames follow an eight-slot TDMA cycle, and one full cycle of slots makes one superframe. A frame-start strobe marks the first bit of each frame, and a superframe-start strobe marks the first bit of slot 0. Header fields, control values, guard length, spacer length and the set of ready messages are all sampled on the first bit of a frame. Changes made later in that frame do not affect it.

Top module: `tdma_framer`

## Requirements
- R1: Each frame carries, in this order: a guard, a 24-bit header, 32 bits of control, then a spacer and a message for each active source in ascending source order. The frame ends after the last message, or after the control bits if no source is active.
- R2: Guard and spacer bits alternate 1,0,1,0 starting with 1 at the start of each section. A guard is `cfg_guard`+1 bits long and a spacer is `cfg_spacer`+1 bits long.
- R3: The header is sent MSB first as the 24-bit word {address[7:0], protocol[3:0], refer[3:0], SF, slot[2:0], 4'b0000}.
- R4: The control bits are sent MSB first as the four bytes {message type, hop offset, total payload bytes of the frame, 8'h00}.
- R5: Message bytes are sent MSB first. `msg_ready[i]` is high, together with `bit_en`, in the cycle that sends the last bit of each byte of source i. Only one source is ready at a time, so each frame has exactly as many ready pulses as it has payload bytes.
- R6: Source i is active only if `msg_valid[i]` is high and its length field is nonzero on the first bit of the frame. An inactive source sends neither its spacer nor its message, and it adds zero to the total byte count.
- R7: All configuration inputs and source valid/length inputs are captured on the first bit of a frame. Changes made after that first bit take effect only in the next frame.
- R8: The slot number is 0 in the first frame after reset. It increases by one per frame and wraps from 7 to 0. The SF header bit is 1 exactly when the slot is 0.
- R9: `frame_start` is high together with the first guard bit of every frame and with no other bit. `sf_start` is high with it only when the frame's slot is 0.
- R10: `ser_valid` is high for one cycle in the cycle after each `bit_en` cycle, and `ser_bit` is valid at that time. Without `bit_en` there is no output strobe and the frame does not advance.
- R11: During and after reset, `ser_valid`, `frame_start`, `sf_start` and `msg_ready` are low until the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate tick; one output bit per tick |
| cfg_addr | input | 8 | Header address field |
| cfg_proto | input | 4 | Header protocol field |
| cfg_refer | input | 4 | Header refer field |
| cfg_type | input | 8 | Message type control word |
| cfg_hop | input | 8 | Hop offset control word |
| cfg_guard | input | 4 | Guard length minus one, in bits |
| cfg_spacer | input | 4 | Spacer length minus one, in bits |
| msg_valid | input | 4 | Per-source message present |
| msg_len | input | 24 | Per-source byte count, 6 bits per source, source 0 in the low bits |
| msg_data | input | 32 | Per-source current byte, 8 bits per source, source 0 in the low bits |
| msg_ready | output | 4 | Per-source byte taken strobe |
| ser_bit | output | 1 | Serial output bit |
| ser_valid | output | 1 | Serial bit strobe |
| frame_start | output | 1 | First bit of a frame |
| sf_start | output | 1 | First bit of a superframe |

## Verification
The embedded properties check on every cycle that at most one source is ready, that ready strobes occur only on a tick, and that a superframe start never appears without a frame start. They also check that the output strobe stays quiet after a cycle with no tick, that the sequencer restarts at the first guard bit after every frame end, and that the slot holds between frames and wraps after 7. Only the directed scenarios can show that the bit content of each section is right. The same holds for skipped sources being left out of the stream and of the byte count, for settings changed in the middle of a frame staying hidden until the next one, and for the SF flag and strobe following the slot cycle over nine frames.

// File: rtl/tfg_pkg.sv
`timescale 1ns/1ps
package tfg_pkg;
  typedef enum logic [2:0] {
    SEC_GUARD,
    SEC_HDR,
    SEC_CTRL,
    SEC_SPC,
    SEC_MSG
  } sec_e;

  localparam int HDR_BITS  = 24;
  localparam int CTRL_BITS = 32;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/tfg_cfg_snap.sv
`timescale 1ns/1ps
module tfg_cfg_snap #(
  parameter int N_MSG = 4,
  parameter int LEN_W = 6,
  parameter int GAP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic                   use_live,
  input  logic [7:0]             live_addr,
  input  logic [3:0]             live_proto,
  input  logic [3:0]             live_refer,
  input  logic [7:0]             live_type,
  input  logic [7:0]             live_hop,
  input  logic [GAP_W-1:0]       live_guard,
  input  logic [GAP_W-1:0]       live_spacer,
  input  logic [N_MSG-1:0]       live_valid,
  input  logic [N_MSG*LEN_W-1:0] live_len,
  output logic [7:0]             eff_addr,
  output logic [3:0]             eff_proto,
  output logic [3:0]             eff_refer,
  output logic [7:0]             eff_type,
  output logic [7:0]             eff_hop,
  output logic [GAP_W-1:0]       eff_guard,
  output logic [GAP_W-1:0]       eff_spacer,
  output logic [N_MSG-1:0]       eff_act,
  output logic [N_MSG*LEN_W-1:0] eff_len
);
  logic [N_MSG-1:0]       live_act;
  logic [7:0]             s_addr, s_type, s_hop;
  logic [3:0]             s_proto, s_refer;
  logic [GAP_W-1:0]       s_guard, s_spacer;
  logic [N_MSG-1:0]       s_act;
  logic [N_MSG*LEN_W-1:0] s_len;

  for (genvar g = 0; g < N_MSG; g++) begin : g_act
    assign live_act[g] = live_valid[g] && (live_len[g*LEN_W +: LEN_W] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr   <= '0;
      s_proto  <= '0;
      s_refer  <= '0;
      s_type   <= '0;
      s_hop    <= '0;
      s_guard  <= '0;
      s_spacer <= '0;
      s_act    <= '0;
      s_len    <= '0;
    end else if (capture) begin
      s_addr   <= live_addr;
      s_proto  <= live_proto;
      s_refer  <= live_refer;
      s_type   <= live_type;
      s_hop    <= live_hop;
      s_guard  <= live_guard;
      s_spacer <= live_spacer;
      s_act    <= live_act;
      s_len    <= live_len;
    end
  end

  always_comb begin
    eff_addr   = use_live ? live_addr   : s_addr;
    eff_proto  = use_live ? live_proto  : s_proto;
    eff_refer  = use_live ? live_refer  : s_refer;
    eff_type   = use_live ? live_type   : s_type;
    eff_hop    = use_live ? live_hop    : s_hop;
    eff_guard  = use_live ? live_guard  : s_guard;
    eff_spacer = use_live ? live_spacer : s_spacer;
    eff_act    = use_live ? live_act    : s_act;
    eff_len    = use_live ? live_len    : s_len;
  end
endmodule

// File: rtl/tfg_seq.sv
`timescale 1ns/1ps
module tfg_seq
  import tfg_pkg::*;
#(
  parameter int N_MSG   = 4,
  parameter int LEN_W   = 6,
  parameter int GAP_W   = 4,
  parameter int N_SLOTS = 8,
  localparam int IW = (N_MSG > 1) ? $clog2(N_MSG) : 1,
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CW = (LEN_W + 3 > 6) ? LEN_W + 3 : 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic [GAP_W-1:0]       guard_len,
  input  logic [GAP_W-1:0]       spacer_len,
  input  logic [N_MSG-1:0]       act,
  input  logic [N_MSG*LEN_W-1:0] lens,
  output sec_e                   sec,
  output logic [IW-1:0]          idx,
  output logic [CW-1:0]          cnt,
  output logic [SW-1:0]          slot,
  output logic                   at_fstart
);
  sec_e            sec_q, sec_n;
  logic [IW-1:0]   idx_q, idx_n, first_idx, next_idx;
  logic [CW-1:0]   cnt_q, cnt_n, msg_last;
  logic [SW-1:0]   slot_q, slot_n;
  logic [LEN_W-1:0] len_cur;
  logic            any_act, has_next, last, frame_end;

  // source search: lowest active, and lowest active above the current one
  always_comb begin
    any_act   = |act;
    first_idx = '0;
    next_idx  = '0;
    has_next  = 1'b0;
    len_cur   = '0;
    for (int i = N_MSG - 1; i >= 0; i--) begin
      if (act[i]) first_idx = IW'(i);
      if (act[i] && (i > int'(idx_q))) begin
        next_idx = IW'(i);
        has_next = 1'b1;
      end
      if (IW'(i) == idx_q) len_cur = lens[i*LEN_W +: LEN_W];
    end
    msg_last = CW'({len_cur, 3'b000}) - CW'(1);
  end

  always_comb begin
    unique case (sec_q)
      SEC_GUARD: last = (cnt_q == CW'(guard_len));
      SEC_HDR:   last = (cnt_q == CW'(HDR_BITS - 1));
      SEC_CTRL:  last = (cnt_q == CW'(CTRL_BITS - 1));
      SEC_SPC:   last = (cnt_q == CW'(spacer_len));
      SEC_MSG:   last = (cnt_q == msg_last);
      default:   last = 1'b1;
    endcase
  end

  always_comb begin
    sec_n     = sec_q;
    idx_n     = idx_q;
    cnt_n     = cnt_q;
    slot_n    = slot_q;
    frame_end = 1'b0;
    if (adv) begin
      if (!last) begin
        cnt_n = cnt_q + CW'(1);
      end else begin
        cnt_n = '0;
        unique case (sec_q)
          SEC_GUARD: sec_n = SEC_HDR;
          SEC_HDR:   sec_n = SEC_CTRL;
          SEC_CTRL: begin
            if (any_act) begin
              sec_n = SEC_SPC;
              idx_n = first_idx;
            end else begin
              sec_n     = SEC_GUARD;
              frame_end = 1'b1;
            end
          end
          SEC_SPC:   sec_n = SEC_MSG;
          SEC_MSG: begin
            if (has_next) begin
              sec_n = SEC_SPC;
              idx_n = next_idx;
            end else begin
              sec_n     = SEC_GUARD;
              frame_end = 1'b1;
            end
          end
          default:   sec_n = SEC_GUARD;
        endcase
      end
      if (frame_end)
        slot_n = (slot_q == SW'(N_SLOTS - 1)) ? '0 : slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= SEC_GUARD;
      idx_q  <= '0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      sec_q  <= sec_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
      slot_q <= slot_n;
    end
  end

  assign sec       = sec_q;
  assign idx       = idx_q;
  assign cnt       = cnt_q;
  assign slot      = slot_q;
  assign at_fstart = (sec_q == SEC_GUARD) && (cnt_q == '0);

  // R8
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && slot_q == SW'(N_SLOTS - 1)) |=> (slot_q == '0));

  // R8
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(slot_q));

  // R1
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (sec_q == SEC_GUARD && cnt_q == '0));
endmodule

// File: rtl/tfg_bit_sel.sv
`timescale 1ns/1ps
module tfg_bit_sel
  import tfg_pkg::*;
#(
  parameter int N_MSG = 4,
  parameter int IW    = 2,
  parameter int CW    = 9
) (
  input  sec_e                    sec,
  input  logic [IW-1:0]           idx,
  input  logic [CW-1:0]           cnt,
  input  logic [2:0]              slot,
  input  logic [7:0]              addr,
  input  logic [3:0]              proto,
  input  logic [3:0]              refer,
  input  logic [7:0]              kind,
  input  logic [7:0]              hop,
  input  logic [7:0]              total,
  input  logic [N_MSG*BYTE_W-1:0] msg_data,
  output logic                    bit_o
);
  logic [HDR_BITS-1:0]  hdr_word, hdr_sh;
  logic [CTRL_BITS-1:0] ctrl_word, ctrl_sh;
  logic [BYTE_W-1:0]    byte_cur, byte_sh;

  always_comb begin
    hdr_word  = {addr, proto, refer, (slot == 3'd0), slot, 4'b0000};
    ctrl_word = {kind, hop, total, 8'h00};
    byte_cur  = '0;
    for (int i = 0; i < N_MSG; i++)
      if (IW'(i) == idx) byte_cur = msg_data[i*BYTE_W +: BYTE_W];
    hdr_sh  = hdr_word << cnt;
    ctrl_sh = ctrl_word << cnt;
    byte_sh = byte_cur << cnt[2:0];
    unique case (sec)
      SEC_HDR:  bit_o = hdr_sh[HDR_BITS-1];
      SEC_CTRL: bit_o = ctrl_sh[CTRL_BITS-1];
      SEC_MSG:  bit_o = byte_sh[BYTE_W-1];
      default:  bit_o = ~cnt[0];
    endcase
  end
endmodule

// File: rtl/tdma_framer.sv
`timescale 1ns/1ps
module tdma_framer
  import tfg_pkg::*;
#(
  parameter int N_MSG   = 4,
  parameter int LEN_W   = 6,
  parameter int GAP_W   = 4,
  parameter int N_SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic [7:0]               cfg_addr,
  input  logic [3:0]               cfg_proto,
  input  logic [3:0]               cfg_refer,
  input  logic [7:0]               cfg_type,
  input  logic [7:0]               cfg_hop,
  input  logic [GAP_W-1:0]         cfg_guard,
  input  logic [GAP_W-1:0]         cfg_spacer,
  input  logic [N_MSG-1:0]         msg_valid,
  input  logic [N_MSG*LEN_W-1:0]   msg_len,
  input  logic [N_MSG*BYTE_W-1:0]  msg_data,
  output logic [N_MSG-1:0]         msg_ready,
  output logic                     ser_bit,
  output logic                     ser_valid,
  output logic                     frame_start,
  output logic                     sf_start
);
  localparam int IW    = (N_MSG > 1) ? $clog2(N_MSG) : 1;
  localparam int SW    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int CW    = (LEN_W + 3 > 6) ? LEN_W + 3 : 6;
  localparam int TOT_W = LEN_W + IW + 1;

  logic [1:0]             rst_pipe;
  logic                   rst_i_n;
  logic [7:0]             e_addr, e_type, e_hop, total8;
  logic [3:0]             e_proto, e_refer;
  logic [GAP_W-1:0]       e_guard, e_spacer;
  logic [N_MSG-1:0]       e_act;
  logic [N_MSG*LEN_W-1:0] e_len;
  logic [TOT_W-1:0]       total;
  sec_e                   sec;
  logic [IW-1:0]          idx;
  logic [CW-1:0]          cnt;
  logic [SW-1:0]          slot;
  logic                   at_fstart, bit_nx, rdy_fire;
  logic                   bit_q, valid_q, fs_q, sfs_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  tfg_cfg_snap #(.N_MSG(N_MSG), .LEN_W(LEN_W), .GAP_W(GAP_W)) i_snap (
    .clk(clk), .rst_n(rst_i_n),
    .capture(bit_en && at_fstart), .use_live(at_fstart),
    .live_addr(cfg_addr), .live_proto(cfg_proto), .live_refer(cfg_refer),
    .live_type(cfg_type), .live_hop(cfg_hop),
    .live_guard(cfg_guard), .live_spacer(cfg_spacer),
    .live_valid(msg_valid), .live_len(msg_len),
    .eff_addr(e_addr), .eff_proto(e_proto), .eff_refer(e_refer),
    .eff_type(e_type), .eff_hop(e_hop),
    .eff_guard(e_guard), .eff_spacer(e_spacer),
    .eff_act(e_act), .eff_len(e_len)
  );

  tfg_seq #(.N_MSG(N_MSG), .LEN_W(LEN_W), .GAP_W(GAP_W), .N_SLOTS(N_SLOTS)) i_seq (
    .clk(clk), .rst_n(rst_i_n), .adv(bit_en),
    .guard_len(e_guard), .spacer_len(e_spacer),
    .act(e_act), .lens(e_len),
    .sec(sec), .idx(idx), .cnt(cnt), .slot(slot), .at_fstart(at_fstart)
  );

  always_comb begin
    total = '0;
    for (int i = 0; i < N_MSG; i++)
      if (e_act[i]) total = total + TOT_W'(e_len[i*LEN_W +: LEN_W]);
    total8 = 8'(total);
  end

  tfg_bit_sel #(.N_MSG(N_MSG), .IW(IW), .CW(CW)) i_bits (
    .sec(sec), .idx(idx), .cnt(cnt), .slot(3'(slot)),
    .addr(e_addr), .proto(e_proto), .refer(e_refer),
    .kind(e_type), .hop(e_hop), .total(total8),
    .msg_data(msg_data), .bit_o(bit_nx)
  );

  assign rdy_fire = bit_en && (sec == SEC_MSG) && (cnt[2:0] == 3'b111);
  for (genvar g = 0; g < N_MSG; g++) begin : g_rdy
    assign msg_ready[g] = rdy_fire && (idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      fs_q    <= 1'b0;
      sfs_q   <= 1'b0;
    end else begin
      valid_q <= bit_en;
      fs_q    <= bit_en && at_fstart;
      sfs_q   <= bit_en && at_fstart && (slot == '0);
      if (bit_en) bit_q <= bit_nx;
    end
  end

  assign ser_bit     = bit_q;
  assign ser_valid   = valid_q;
  assign frame_start = fs_q;
  assign sf_start    = sfs_q;

  // R5
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(msg_ready));

  // R5
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|msg_ready) |-> bit_en);

  // R9
  sf_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    sf_start |-> frame_start);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bit_en |=> !ser_valid);
endmodule

// File: tb/test_tdma_framer.sv
`timescale 1ns/1ps
module test_tdma_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic [7:0]  cfg_addr, cfg_type, cfg_hop;
  logic [3:0]  cfg_proto, cfg_refer, cfg_guard, cfg_spacer;
  logic [3:0]  msg_valid;
  logic [23:0] msg_len;
  logic [31:0] msg_data;
  logic [3:0]  msg_ready;
  logic        ser_bit, ser_valid, frame_start, sf_start;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int ptr [4];
  int exp_slot = 0;
  logic exp_b [0:2047];
  logic cap_b [0:2047];
  int exp_len, hdr_at, ctrl_at, tot_bytes;

  always #2 clk = ~clk;

  tdma_framer i_tdma_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_addr(cfg_addr), .cfg_proto(cfg_proto), .cfg_refer(cfg_refer),
    .cfg_type(cfg_type), .cfg_hop(cfg_hop),
    .cfg_guard(cfg_guard), .cfg_spacer(cfg_spacer),
    .msg_valid(msg_valid), .msg_len(msg_len), .msg_data(msg_data),
    .msg_ready(msg_ready), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .frame_start(frame_start), .sf_start(sf_start)
  );

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int i, input int k);
    return 8'((60 + i * 81 + k * 29) % 256);
  endfunction

  task automatic refresh_data();
    for (int i = 0; i < 4; i++) msg_data[i*8 +: 8] = src_byte(i, ptr[i]);
  endtask

  task automatic push(input logic v);
    exp_b[exp_len] = v;
    exp_len++;
  endtask

  // expected frame from the requirements, using the inputs as they stand
  task automatic build_frame();
    logic [23:0] hv;
    logic [31:0] cv;
    int len;
    exp_len   = 0;
    tot_bytes = 0;
    for (int i = 0; i < 4; i++) begin
      len = int'(msg_len[i*6 +: 6]);
      if (msg_valid[i] && len != 0) tot_bytes += len;
    end
    for (int k = 0; k <= int'(cfg_guard); k++) push(k % 2 == 0);
    hdr_at = exp_len;
    hv = {cfg_addr, cfg_proto, cfg_refer, (exp_slot == 0), 3'(exp_slot), 4'b0000};
    for (int b = 23; b >= 0; b--) push(hv[b]);
    ctrl_at = exp_len;
    cv = {cfg_type, cfg_hop, 8'(tot_bytes), 8'h00};
    for (int b = 31; b >= 0; b--) push(cv[b]);
    for (int i = 0; i < 4; i++) begin
      len = int'(msg_len[i*6 +: 6]);
      if (msg_valid[i] && len != 0) begin
        for (int k = 0; k <= int'(cfg_spacer); k++) push(k % 2 == 0);
        for (int k = 0; k < len; k++)
          for (int b = 7; b >= 0; b--) push(src_byte(i, k)[b]);
      end
    end
  endtask

  task automatic tick(output logic b, output logic fs, output logic sfs,
                      output logic [3:0] rdy, output logic vok);
    @(negedge clk);
    bit_en = 1'b1;
    #1 rdy = msg_ready;
    @(posedge clk);
    #1 bit_en = 1'b0;
    for (int i = 0; i < 4; i++) if (rdy[i]) ptr[i]++;
    refresh_data();
    @(negedge clk);
    b = ser_bit; fs = frame_start; sfs = sf_start; vok = ser_valid;
  endtask

  task automatic cmp_range(input string tag, input int lo, input int hi);
    int bad = -1;
    for (int t = hi; t >= lo; t--) if (cap_b[t] !== exp_b[t]) bad = t;
    if (bad < 0) check(tag, 1'b1, 0, 0);
    else begin
      check(tag, 1'b0, int'(cap_b[bad]), int'(exp_b[bad]));
      $display("     first mismatch at frame bit %0d", bad);
    end
  endtask

  task automatic apply_alt();
    cfg_addr  = 8'hC3;
    cfg_type  = 8'h77;
    cfg_guard = 4'd1;
    cfg_spacer = 4'd3;
    msg_valid = ~msg_valid;
    msg_len[5:0] = 6'd1;
  endtask

  task automatic run_frame(input string tag, input bit chg);
    logic b, fs, sfs, vok;
    logic [3:0] rdy;
    int extra = 0, rdy_n = 0, multi = 0, vbad = 0;
    logic fs0 = 1'b0, sfs0 = 1'b0;
    build_frame();
    for (int i = 0; i < 4; i++) ptr[i] = 0;
    refresh_data();
    for (int t = 0; t < exp_len; t++) begin
      tick(b, fs, sfs, rdy, vok);
      cap_b[t] = b;
      if (t == 0) begin fs0 = fs; sfs0 = sfs; end
      else if (fs || sfs) extra++;
      if (rdy != 0) rdy_n++;
      if ($countones(rdy) > 1) multi++;
      if (!vok) vbad++;
      if (chg && t == 0) apply_alt();
    end
    cmp_range(tag, 0, exp_len - 1);
    cmp_range("R2 guard pattern", 0, hdr_at - 1);
    cmp_range("R3 header", hdr_at, ctrl_at - 1);
    cmp_range("R4 control", ctrl_at, ctrl_at + 31);
    check("R9 frame_start on first bit only", fs0 && extra == 0, int'(fs0), 1);
    check("R9 R8 sf_start by slot", sfs0 == (exp_slot == 0), int'(sfs0), int'(exp_slot == 0));
    check("R5 ready pulses", rdy_n == tot_bytes && multi == 0, rdy_n, tot_bytes);
    check("R10 ser_valid per tick", vbad == 0, vbad, 0);
    exp_slot = (exp_slot + 1) % 8;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_en = 1'b0;
    cfg_addr = 8'hA6; cfg_proto = 4'h9; cfg_refer = 4'h3;
    cfg_type = 8'h21; cfg_hop = 8'h0E;
    cfg_guard = 4'd3; cfg_spacer = 4'd2;
    msg_valid = 4'b1111;
    msg_len = {6'd3, 6'd1, 6'd2, 6'd1};
    for (int i = 0; i < 4; i++) ptr[i] = 0;
    refresh_data();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 outputs low in reset", !ser_valid && !frame_start && !sf_start && msg_ready == 0,
          int'({ser_valid, frame_start, sf_start}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 outputs low after reset", !ser_valid && !frame_start && !sf_start && msg_ready == 0,
          int'({ser_valid, frame_start, sf_start}), 0);
  endtask

  task automatic t_basic();
    run_frame("R1 full frame four sources", 1'b0);
  endtask

  task automatic t_skip();
    msg_valid = 4'b1101;
    msg_len = {6'd0, 6'd2, 6'd4, 6'd1};
    cfg_addr = 8'h3D; cfg_type = 8'h05;
    run_frame("R6 skipped sources", 1'b0);
  endtask

  task automatic t_empty();
    msg_valid = 4'b0000;
    run_frame("R1 frame with no messages", 1'b0);
  endtask

  task automatic t_cfg_change();
    cfg_guard = 4'd5; cfg_spacer = 4'd0;
    msg_valid = 4'b0110;
    msg_len = {6'd1, 6'd2, 6'd1, 6'd2};
    run_frame("R7 mid-frame change ignored", 1'b1);
    run_frame("R7 new settings next frame", 1'b0);
  endtask

  task automatic t_idle();
    int seen = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (ser_valid || frame_start) seen++;
    end
    check("R10 no strobe without tick", seen == 0, seen, 0);
    run_frame("R10 frame intact after idle", 1'b0);
  endtask

  task automatic t_wrap();
    msg_valid = 4'b0000;
    cfg_guard = 4'd0;
    for (int f = 0; f < 3; f++) run_frame("R8 slot wrap frames", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_skip();
    t_empty();
    t_cfg_change();
    t_idle();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule